// File: doc/BRIEF.md
# Crossover-Resolving Copper Port Bring-Up Sequencer

This block brings up a copper Ethernet port whose cable wiring (straight or crossed) is not known in advance. After a start pulse it selects straight-through (MDI) wiring, lets the line settle for a fixed interval, and then asks the PHY whether link is up. Each time the answer is no, it swaps the wiring choice and tries again. It gives up after a bounded number of attempts and raises a failure flag.

Once link is seen, the block reads a chain of PHY registers through a request/acknowledge MDIO read port. Each read in the chain is issued only when an earlier result allows it. The results give the resolved speed, the duplex mode and whether both ends agreed on pause frames. The block then emits a four-bit port-status word in one write and holds it until the next start. The MDIO serial engine sits outside the block and is reached through the read port.

Top module: `xover_link_seq`

## Requirements
- R1: The cycle after a start pulse is accepted, the crossover select is 0 (MDI), the failure flag is 0 and the status word is 0.
- R2: Each link probe read is issued no earlier than CLK_HZ*WAIT_SEC cycles after the start, or after the previous failed probe.
- R3: Every read request carries PHY address PHY_ADDR (default 6). A link probe reads register 1, and bit 2 of the result means link up.
- R4: After a probe that finds no link, the crossover select inverts before the next probe (1 = MDIX). It changes at no other time except the clear on start.
- R5: After MAX_TRIES probes without link, the failure flag goes to 1 and the done pulse fires. No further reads are issued, and the status word stays 0.
- R6: After link is found, register 1 is read again. Register 31 is read only if bit 5 of that result is set. If bit 5 is clear, the sequence ends with done and with no status write.
- R7: Bits 4:2 of register 31 set status bit 1 (100 Mb/s) and status bit 2 (full duplex). The codes are 1→10 half, 5→10 full, 2→100 half and 6→100 full. Any other code gives 0 for both bits.
- R8: Register 6 is read only if bit 3 of the second register-1 result is set. Register 4 is read only if bit 0 of register 6 is set. Register 5 is read only if bit 10 of register 4 is set. Status bit 3 (pause) is bit 10 of register 5 and is 0 when register 5 is not read.
- R9: At the end of a successful chain, status bit 0 (link) is 1 and the word is written once, with a one-cycle status_we that coincides with seq_done. The word then holds until the next start.
- R10: mdio_req is a one-cycle pulse, never asserted while mdio_busy is high. A result is used only after busy has dropped.
- R11: A start pulse that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a bring-up sequence when idle |
| xover_sel | output | 1 | Wiring select: 0 MDI, 1 MDIX |
| mdio_req | output | 1 | One-cycle read request strobe |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register address of the request |
| mdio_busy | input | 1 | High while the MDIO engine is working on a read |
| mdio_rdata | input | 16 | Read result, valid when busy falls |
| port_status | output | 4 | {pause, full duplex, 100 Mb/s, link} |
| status_we | output | 1 | One-cycle write strobe for port_status |
| seq_done | output | 1 | One-cycle pulse at the end of any sequence |
| link_fail | output | 1 | Set when all probes failed; cleared on start |

## Verification
The PHY model answers the link probe on the first, second or third attempt, or never. The register trail and the crossover value at each request then show whether the toggle happens on every miss and stays put on the hit. Separate register contents stop the post-link chain at each gate in turn: bit 5 clear, no negotiation ability, partner not negotiating, no local pause, no partner pause. The exact read trail separates a wrongly taken branch from a skipped one. All four speed/duplex codes and one undefined code check the mode mapping. A second start pulse during the settling wait must leave the read trail unchanged.

// File: rtl/xover_link_pkg.sv
package xover_link_pkg;

  localparam int REG_W  = 5;
  localparam int DATA_W = 16;

  // PHY register addresses used by the chain
  localparam logic [REG_W-1:0] RA_BASIC_STAT = 5'd1;
  localparam logic [REG_W-1:0] RA_ADV        = 5'd4;
  localparam logic [REG_W-1:0] RA_LP_ADV     = 5'd5;
  localparam logic [REG_W-1:0] RA_AN_EXP     = 5'd6;
  localparam logic [REG_W-1:0] RA_VEND_STAT  = 5'd31;

  // bit positions inside read results
  localparam int B_LINK       = 2;
  localparam int B_AN_ABLE    = 3;
  localparam int B_AN_DONE    = 5;
  localparam int B_LP_AN_ABLE = 0;
  localparam int B_PAUSE      = 10;
  localparam int MODE_LSB     = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DELAY, ST_LINK, ST_RECHK, ST_MODE, ST_EXP, ST_ADV, ST_LPADV
  } seq_state_t;

  typedef struct packed {
    logic pause;
    logic full_dup;
    logic fast;
    logic link;
  } port_stat_t;

  // returns {full_dup, fast}
  function automatic logic [1:0] mode_to_dup_fast(input logic [2:0] code);
    case (code)
      3'd1:    return 2'b00;
      3'd5:    return 2'b10;
      3'd2:    return 2'b01;
      3'd6:    return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic port_stat_t make_stat(input logic pause, input logic [1:0] dup_fast);
    port_stat_t s;
    s.pause    = pause;
    s.full_dup = dup_fast[1];
    s.fast     = dup_fast[0];
    s.link     = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/xls_interval_timer.sv
module xls_interval_timer #(
  parameter int unsigned CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expire
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (arm) begin
      cnt <= CW'(CYCLES - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expire = run && (cnt == '0);
endmodule

// File: rtl/xls_mdio_reader.sv
module xls_mdio_reader
  import xover_link_pkg::*;
#(
  parameter logic [REG_W-1:0] PHY_ADDR = 5'd6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [REG_W-1:0]  go_reg,
  output logic              mdio_req,
  output logic [REG_W-1:0]  mdio_phy,
  output logic [REG_W-1:0]  mdio_reg,
  input  logic              mdio_busy,
  input  logic [DATA_W-1:0] mdio_rdata,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);
  typedef enum logic [1:0] {RD_IDLE, RD_GAP, RD_WAIT} rd_state_t;
  rd_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RD_IDLE;
      mdio_req <= 1'b0;
      mdio_reg <= '0;
      rd_done  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_done <= 1'b0;
      case (st)
        RD_IDLE: if (go) begin
          mdio_req <= 1'b1;
          mdio_reg <= go_reg;
          st       <= RD_GAP;
        end
        RD_GAP: begin
          // engine raises busy one cycle after the strobe
          mdio_req <= 1'b0;
          st       <= RD_WAIT;
        end
        RD_WAIT: if (!mdio_busy) begin
          rd_data <= mdio_rdata;
          rd_done <= 1'b1;
          st      <= RD_IDLE;
        end
        default: st <= RD_IDLE;
      endcase
    end
  end

  assign mdio_phy = PHY_ADDR;
endmodule

// File: rtl/xover_link_seq.sv
module xover_link_seq
  import xover_link_pkg::*;
#(
  parameter int unsigned      CLK_HZ    = 50_000_000,
  parameter int unsigned      WAIT_SEC  = 2,
  parameter int unsigned      MAX_TRIES = 100,
  parameter logic [REG_W-1:0] PHY_ADDR  = 5'd6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              xover_sel,
  output logic              mdio_req,
  output logic [REG_W-1:0]  mdio_phy,
  output logic [REG_W-1:0]  mdio_reg,
  input  logic              mdio_busy,
  input  logic [DATA_W-1:0] mdio_rdata,
  output logic [3:0]        port_status,
  output logic              status_we,
  output logic              seq_done,
  output logic              link_fail
);
  localparam int unsigned WAIT_CYC = CLK_HZ * WAIT_SEC;
  localparam int          TRY_W    = $clog2(MAX_TRIES + 1);

  seq_state_t        state;
  logic [TRY_W-1:0]  tries;
  port_stat_t        stat_q;
  logic [1:0]        df_q;
  logic              an_able_q;

  // named internal events
  logic              start_take;
  logic              delay_arm;
  logic              delay_hit;
  logic              rd_go;
  logic [REG_W-1:0]  rd_reg;
  logic              rd_done;
  logic [DATA_W-1:0] rd_data;

  assign start_take = start && (state == ST_IDLE);

  xls_interval_timer #(.CYCLES(WAIT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(delay_arm), .expire(delay_hit)
  );

  xls_mdio_reader #(.PHY_ADDR(PHY_ADDR)) u_reader (
    .clk(clk), .rst_n(rst_n), .go(rd_go), .go_reg(rd_reg),
    .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_busy(mdio_busy), .mdio_rdata(mdio_rdata),
    .rd_done(rd_done), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      xover_sel <= 1'b0;
      tries     <= '0;
      stat_q    <= '0;
      df_q      <= '0;
      an_able_q <= 1'b0;
      status_we <= 1'b0;
      seq_done  <= 1'b0;
      link_fail <= 1'b0;
      delay_arm <= 1'b0;
      rd_go     <= 1'b0;
      rd_reg    <= '0;
    end else begin
      status_we <= 1'b0;
      seq_done  <= 1'b0;
      delay_arm <= 1'b0;
      rd_go     <= 1'b0;
      case (state)
        ST_IDLE: if (start_take) begin
          xover_sel <= 1'b0;
          tries     <= '0;
          stat_q    <= '0;
          link_fail <= 1'b0;
          delay_arm <= 1'b1;
          state     <= ST_DELAY;
        end
        ST_DELAY: if (delay_hit) begin
          rd_go  <= 1'b1;
          rd_reg <= RA_BASIC_STAT;
          state  <= ST_LINK;
        end
        ST_LINK: if (rd_done) begin
          if (rd_data[B_LINK]) begin
            rd_go  <= 1'b1;
            rd_reg <= RA_BASIC_STAT;
            state  <= ST_RECHK;
          end else if (tries == TRY_W'(MAX_TRIES - 1)) begin
            link_fail <= 1'b1;
            seq_done  <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            tries     <= tries + 1'b1;
            xover_sel <= ~xover_sel;
            delay_arm <= 1'b1;
            state     <= ST_DELAY;
          end
        end
        ST_RECHK: if (rd_done) begin
          an_able_q <= rd_data[B_AN_ABLE];
          if (rd_data[B_AN_DONE]) begin
            rd_go  <= 1'b1;
            rd_reg <= RA_VEND_STAT;
            state  <= ST_MODE;
          end else begin
            seq_done <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_MODE: if (rd_done) begin
          df_q <= mode_to_dup_fast(rd_data[MODE_LSB +: 3]);
          if (an_able_q) begin
            rd_go  <= 1'b1;
            rd_reg <= RA_AN_EXP;
            state  <= ST_EXP;
          end else begin
            stat_q    <= make_stat(1'b0, mode_to_dup_fast(rd_data[MODE_LSB +: 3]));
            status_we <= 1'b1;
            seq_done  <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_EXP: if (rd_done) begin
          if (rd_data[B_LP_AN_ABLE]) begin
            rd_go  <= 1'b1;
            rd_reg <= RA_ADV;
            state  <= ST_ADV;
          end else begin
            stat_q    <= make_stat(1'b0, df_q);
            status_we <= 1'b1;
            seq_done  <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_ADV: if (rd_done) begin
          if (rd_data[B_PAUSE]) begin
            rd_go  <= 1'b1;
            rd_reg <= RA_LP_ADV;
            state  <= ST_LPADV;
          end else begin
            stat_q    <= make_stat(1'b0, df_q);
            status_we <= 1'b1;
            seq_done  <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_LPADV: if (rd_done) begin
          stat_q    <= make_stat(rd_data[B_PAUSE], df_q);
          status_we <= 1'b1;
          seq_done  <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign port_status = stat_q;
endmodule

// File: rtl/xover_link_seq_chk.sv
module xover_link_seq_chk #(
  parameter int unsigned WAIT_CYC = 20,
  parameter logic [4:0]  PHY_ADDR = 5'd6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_take,
  input logic       delay_arm,
  input logic       delay_hit,
  input logic       mdio_req,
  input logic [4:0] mdio_phy,
  input logic       mdio_busy,
  input logic       xover_sel,
  input logic [3:0] port_status,
  input logic       status_we,
  input logic       link_fail
);
  logic [31:0] since_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    since_arm <= '0;
    else if (delay_arm)                            since_arm <= 32'd1;
    else if (since_arm != '0 && since_arm != '1)   since_arm <= since_arm + 1'b1;
  end

  assert_interval_R2: assert property (@(posedge clk) disable iff (!rst_n)
    delay_hit |-> since_arm == WAIT_CYC);

  assert_phy_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |-> mdio_phy == PHY_ADDR);

  assert_start_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> (!xover_sel && !link_fail && port_status == 4'd0));

  assert_toggle_only_on_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xover_sel != $past(xover_sel)) |-> delay_arm);

  assert_fail_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |-> !mdio_req);

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_status != $past(port_status)) |-> (status_we || $past(start_take)));

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |=> !mdio_req);

  assert_req_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_busy |-> !mdio_req);
endmodule

bind xover_link_seq xover_link_seq_chk #(.WAIT_CYC(WAIT_CYC), .PHY_ADDR(PHY_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_take(start_take), .delay_arm(delay_arm),
  .delay_hit(delay_hit), .mdio_req(mdio_req), .mdio_phy(mdio_phy),
  .mdio_busy(mdio_busy), .xover_sel(xover_sel), .port_status(port_status),
  .status_we(status_we), .link_fail(link_fail)
);

// File: tb/tb_xover_link_seq.sv
module tb_xover_link_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 10;
  localparam int WAIT_CYC   = CLK_HZ * 2;
  localparam int MAX_TRIES  = 100;
  localparam int LAT        = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        xover_sel, mdio_req, mdio_busy, status_we, seq_done, link_fail;
  logic [4:0]  mdio_phy, mdio_reg;
  logic [15:0] mdio_rdata;
  logic [3:0]  port_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  xover_link_seq #(.CLK_HZ(CLK_HZ), .WAIT_SEC(2), .MAX_TRIES(MAX_TRIES)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .xover_sel(xover_sel),
    .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_busy(mdio_busy), .mdio_rdata(mdio_rdata), .port_status(port_status),
    .status_we(status_we), .seq_done(seq_done), .link_fail(link_fail)
  );

  int n_chk = 0, n_bad = 0, done_seen = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- PHY / MDIO engine model ----------------
  int          link_at;
  logic [15:0] r1_post, r31_v, r6_v, r4_v, r5_v;
  int          basic_cnt;
  int          lat_cnt;
  logic [4:0]  pend_reg;

  always @(posedge clk) begin
    if (!rst_n) begin
      mdio_busy <= 1'b0; mdio_rdata <= '0; basic_cnt <= 0; lat_cnt <= 0; pend_reg <= '0;
    end else begin
      if (start && !mdio_busy && basic_cnt == 0) basic_cnt <= 0;
      if (mdio_req) begin
        mdio_busy <= 1'b1; lat_cnt <= LAT; pend_reg <= mdio_reg;
        if (mdio_reg == 5'd1) basic_cnt <= basic_cnt + 1;
      end else if (mdio_busy) begin
        if (lat_cnt == 1) begin
          mdio_busy <= 1'b0;
          case (pend_reg)
            5'd1:    mdio_rdata <= (link_at == 0 || basic_cnt < link_at) ? 16'h0000 :
                                   (basic_cnt == link_at) ? 16'h0004 : r1_post;
            5'd31:   mdio_rdata <= r31_v;
            5'd6:    mdio_rdata <= r6_v;
            5'd4:    mdio_rdata <= r4_v;
            5'd5:    mdio_rdata <= r5_v;
            default: mdio_rdata <= 16'hDEAD;
          endcase
        end else lat_cnt <= lat_cnt - 1;
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [5:0] exp_q[$];       // {xover, reg}
  logic [3:0] exp_stat;
  logic       exp_we, exp_fail;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mdio_req) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R6/R8 unexpected read", {26'd0, xover_sel, mdio_reg}, 32'h0);
        else begin
          logic [5:0] e;
          e = exp_q.pop_front();
          chk({xover_sel, mdio_reg} == e, "R3/R4/R6/R8 read trail", {26'd0, xover_sel, mdio_reg}, {26'd0, e});
          chk(mdio_phy == 5'd6, "R3 phy address", {27'd0, mdio_phy}, 32'd6);
        end
      end
      if (seq_done) begin
        chk(port_status == exp_stat, "R7/R8/R9 status word", {28'd0, port_status}, {28'd0, exp_stat});
        chk(status_we == exp_we, "R6/R9 status write", {31'd0, status_we}, {31'd0, exp_we});
        chk(link_fail == exp_fail, "R5 fail flag", {31'd0, link_fail}, {31'd0, exp_fail});
        chk(exp_q.size() == 0, "R6/R8 missing reads", exp_q.size(), 32'd0);
        done_seen++;
      end
    end
  end

  task automatic run_case(input int la, input logic [15:0] r1p, r31, r6, r4, r5,
                          input logic [3:0] est, input logic ewe, input bit late_start);
    int n, d0, cyc;
    logic x;
    link_at = la; r1_post = r1p; r31_v = r31; r6_v = r6; r4_v = r4; r5_v = r5;
    exp_stat = est; exp_we = ewe; exp_fail = (la == 0);
    n = (la == 0) ? MAX_TRIES : la;
    for (int i = 1; i <= n; i++) exp_q.push_back({1'((i-1) % 2), 5'd1});
    if (la != 0) begin
      x = 1'((la-1) % 2);
      exp_q.push_back({x, 5'd1});
      if (r1p[5]) begin
        exp_q.push_back({x, 5'd31});
        if (r1p[3]) begin
          exp_q.push_back({x, 5'd6});
          if (r6[0]) begin
            exp_q.push_back({x, 5'd4});
            if (r4[10]) exp_q.push_back({x, 5'd5});
          end
        end
      end
    end
    @(negedge clk); basic_cnt = 0;
    d0 = done_seen;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(xover_sel == 1'b0 && link_fail == 1'b0 && port_status == 4'd0, "R1 cleared on start",
        {29'd0, xover_sel, link_fail, |port_status}, 32'd0);
    cyc = 1;
    while (!mdio_req && cyc < 10*WAIT_CYC) begin
      if (late_start && cyc == 5) start = 1'b1;   // R11: start while running
      else start = 1'b0;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    chk(cyc >= WAIT_CYC, "R2 settle interval", cyc, WAIT_CYC);
    cyc = 0;
    while (done_seen == d0 && cyc < 6000) begin @(negedge clk); cyc++; end
    chk(done_seen != d0, "R10 sequence completes", done_seen, d0 + 1);
    repeat (6) @(negedge clk);
    chk(port_status == est, "R9 status held", {28'd0, port_status}, {28'd0, est});
    chk(link_fail == (la == 0), "R5 fail held", {31'd0, link_fail}, {31'd0, la == 0});
    chk(!mdio_req, "R5/R10 quiet after end", {31'd0, mdio_req}, 32'd0);
  endtask

  initial begin
    link_at = 1; r1_post = 0; r31_v = 0; r6_v = 0; r4_v = 0; r5_v = 0;
    exp_stat = 0; exp_we = 0; exp_fail = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(xover_sel == 0 && port_status == 0 && link_fail == 0 && mdio_req == 0 && status_we == 0,
        "R1 reset state", {27'd0, xover_sel, port_status}, 32'd0);
    // R8/R7: full chain, 100 full, pause agreed
    run_case(1, 16'h002C, 16'h0018, 16'h0001, 16'h0400, 16'h0400, 4'b1111, 1'b1, 1'b0);
    // R4: link on third probe, 10 half, no negotiation ability
    run_case(3, 16'h0024, 16'h0004, 16'h0000, 16'h0000, 16'h0000, 4'b0001, 1'b1, 1'b0);
    // R4/R8: link on second probe (MDIX), 10 full, partner not negotiating
    run_case(2, 16'h002C, 16'h0014, 16'h0000, 16'h0400, 16'h0400, 4'b0101, 1'b1, 1'b0);
    // R7/R8: 100 half, partner lacks pause
    run_case(1, 16'h002C, 16'h0008, 16'h0001, 16'h0400, 16'h0000, 4'b0011, 1'b1, 1'b0);
    // R6: negotiation not complete, no status write
    run_case(1, 16'h000C, 16'h0018, 16'h0001, 16'h0400, 16'h0400, 4'b0000, 1'b0, 1'b0);
    // R7/R8: undefined mode code, no local pause advertised
    run_case(1, 16'h0028, 16'h000C, 16'h0001, 16'h0000, 16'h0400, 4'b0001, 1'b1, 1'b0);
    // R5: never links
    run_case(0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'b0000, 1'b0, 1'b0);
    // R11: second start during the wait is ignored; R1 clears the fail flag
    run_case(1, 16'h002C, 16'h0018, 16'h0001, 16'h0400, 16'h0400, 4'b1111, 1'b1, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=hang expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule